// File: doc/BRIEF.md
# Rename-Stage Move Elimination and Zero-Idiom Unit

This block sits beside the register rename table and looks at one uop per cycle. It picks out two kinds of uop that can complete without an execution port. The first is a 32-bit XOR of a register with itself, which produces zero. The second is a register-to-register copy, either a full-width move or a zero-extension of a low byte, between two different architectural registers. A zeroing idiom gets the fixed zero tag, physical tag 0, and it marks the destination's high-byte partial state as clean. An eliminated copy reuses the physical tag that the source already holds. Every other uop gets the freshly allocated tag and is flagged as needing an ALU port, along with its latency.

Several architectural registers can share one physical tag after eliminated copies. The block therefore keeps a saturating reference count for each physical tag. When the last mapping that points at a tag is overwritten, the block reports that tag as free. When a source tag's count is already at its ceiling, the copy is issued as a normal ALU uop instead. The rename table and the free list stay outside this block. The caller supplies the source tag, the destination's previous tag and a newly allocated tag, and applies the chosen destination tag.

Top module: `me_rename_elim`

## Requirements
- R1: Op code 1 (XOR) with source equal to destination is a zeroing idiom. The outputs are eliminated=1, port=0, tag=0, latency=0 and clean-high=1.
- R2: An XOR of two different registers is an ALU uop. The outputs are eliminated=0, port=1, tag=the new tag, latency=1 and clean-high=0.
- R3: Op code 2 (full move) between different registers is eliminated. The outputs are port=0, tag=the source tag and latency=0.
- R4: Op code 3 (zero-extend from low byte) between different registers is eliminated in the same way as R3.
- R5: A move or low-byte zero-extension whose source and destination are the same register is not eliminated. It gets port=1, tag=the new tag and latency=1.
- R6: Op code 4 (zero-extend from high byte) is never eliminated. It gets port=1 and latency=2.
- R7: Op code 5 (byte move into a high byte), op code 6 (move of an immediate, including zero) and op code 0 (any other uop) are ALU uops with latency 1.
- R8: After reset, architectural register r maps to tag r+1 with a count of one. A tag is reported free, with its number, exactly when its last mapping is overwritten. Tag 0 is never reported free.
- R9: A copy whose source tag count is at its ceiling, 2^CNT_W-1, falls back to an ALU uop with the new tag.
- R10: With the valid input low, all flags are low and no counts change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Uop present this cycle |
| in_op | input | 3 | Uop class code |
| in_dst | input | ARCH_W | Destination architectural register |
| in_src | input | ARCH_W | Source architectural register |
| in_src_tag | input | TAG_W | Current physical tag of the source |
| in_new_tag | input | TAG_W | Freshly allocated physical tag |
| in_old_tag | input | TAG_W | Destination's previous physical tag |
| out_elim | output | 1 | Uop finishes at rename |
| out_port | output | 1 | Uop needs an ALU port |
| out_tag | output | TAG_W | Physical tag for the destination |
| out_lat | output | 2 | Result latency in cycles |
| out_clean_hi | output | 1 | Clear the destination's dirty high-byte state |
| out_free | output | 1 | A tag is returned this cycle |
| out_free_tag | output | TAG_W | Tag being returned |

## Verification
The bench builds the block with 8 architectural registers, 16 physical tags and 2-bit counters. With these values the count ceiling of 3 is reached after only two aliasing copies, so the fallback of R9 is exercised directly. The small tag pool also forces freed tags to be reused. A model of the mapping and the counts, written from the requirements, predicts every output, including which copy removes the last reference to a shared tag.

// File: rtl/me_pkg.sv
// Shared uop class codes for the move-elimination unit.
package me_pkg;
    typedef enum logic [2:0] {
        OP_OTHER   = 3'd0,
        OP_XOR     = 3'd1,
        OP_MOV     = 3'd2,
        OP_MOVZ_LO = 3'd3,
        OP_MOVZ_HI = 3'd4,
        OP_MOV_HI8 = 3'd5,
        OP_MOV_IMM = 3'd6
    } me_op_e;
endpackage

// File: rtl/me_classify.sv
// Classifies one uop from its class code and register numbers.
// Assumes: register numbers are architectural; no state is held here.
module me_classify #(
    parameter int ARCH_W = 4
) (
    input  logic [2:0]        op,
    input  logic [ARCH_W-1:0] dst,
    input  logic [ARCH_W-1:0] src,
    output logic              zero_idiom,
    output logic              copy_cand,
    output logic              slow_hi
);
    import me_pkg::*;

    // Decide the uop class from the op code and register identity.
    always_comb begin
        zero_idiom = (op == OP_XOR) && (dst == src);
        copy_cand  = ((op == OP_MOV) || (op == OP_MOVZ_LO)) && (dst != src);
        slow_hi    = (op == OP_MOVZ_HI);
    end
endmodule

// File: rtl/me_refcnt.sv
// Per-tag saturating reference counters.
// Assumes: tag 0 is the constant zero tag and is never counted; tags
// 1..NUM_ARCH start with one reference each after reset.
module me_refcnt #(
    parameter int NUM_PHYS = 64,
    parameter int NUM_ARCH = 16,
    parameter int CNT_W    = 3,
    localparam int TAG_W   = $clog2(NUM_PHYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [TAG_W-1:0] inc_tag,
    input  logic [TAG_W-1:0] dec_tag,
    input  logic [TAG_W-1:0] probe_sat_tag,
    input  logic [TAG_W-1:0] probe_last_tag,
    output logic             sat,
    output logic             last
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt [NUM_PHYS];

    // Tag 0 holds no count.
    assign cnt[0] = '0;

    for (genvar g = 1; g < NUM_PHYS; g++) begin : g_cnt
        localparam logic [CNT_W-1:0] INIT = (g <= NUM_ARCH) ? CNT_W'(1) : '0;
        logic hit_inc, hit_dec;
        assign hit_inc = upd && (inc_tag == TAG_W'(g)) && (inc_tag != dec_tag);
        assign hit_dec = upd && (dec_tag == TAG_W'(g)) && (inc_tag != dec_tag);
        // Move the count of this tag up or down by one.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt[g] <= INIT;
            else if (hit_inc && cnt[g] != CNT_MAX)
                cnt[g] <= cnt[g] + CNT_W'(1);
            else if (hit_dec && cnt[g] != '0)
                cnt[g] <= cnt[g] - CNT_W'(1);
        end
    end

    assign sat  = (cnt[probe_sat_tag] == CNT_MAX);
    assign last = (cnt[probe_last_tag] == CNT_W'(1));
endmodule

// File: rtl/me_rename_elim.sv
// Rename-stage zero-idiom and move-elimination unit.
// Picks the destination tag, the port need and the latency of each uop,
// and returns a tag to the caller's free list when its last mapping goes.
// Assumes: in_new_tag has count zero; the caller applies out_tag.
module me_rename_elim #(
    parameter int NUM_ARCH = 16,
    parameter int NUM_PHYS = 64,
    parameter int CNT_W    = 3,
    localparam int ARCH_W  = $clog2(NUM_ARCH),
    localparam int TAG_W   = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [ARCH_W-1:0] in_dst,
    input  logic [ARCH_W-1:0] in_src,
    input  logic [TAG_W-1:0]  in_src_tag,
    input  logic [TAG_W-1:0]  in_new_tag,
    input  logic [TAG_W-1:0]  in_old_tag,
    output logic              out_elim,
    output logic              out_port,
    output logic [TAG_W-1:0]  out_tag,
    output logic [1:0]        out_lat,
    output logic              out_clean_hi,
    output logic              out_free,
    output logic [TAG_W-1:0]  out_free_tag
);
    logic zero_idiom, copy_cand, slow_hi, src_sat, old_last;
    logic [TAG_W-1:0] pick_tag;

    me_classify #(.ARCH_W(ARCH_W)) i_cls (
        .op(in_op), .dst(in_dst), .src(in_src),
        .zero_idiom(zero_idiom), .copy_cand(copy_cand), .slow_hi(slow_hi)
    );

    me_refcnt #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH), .CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .upd(in_valid),
        .inc_tag(pick_tag), .dec_tag(in_old_tag),
        .probe_sat_tag(in_src_tag), .probe_last_tag(in_old_tag),
        .sat(src_sat), .last(old_last)
    );

    // Choose the destination tag, the port need and the latency.
    always_comb begin
        out_elim     = 1'b0;
        out_port     = 1'b0;
        out_lat      = 2'd0;
        out_clean_hi = 1'b0;
        pick_tag     = in_new_tag;
        if (zero_idiom) begin
            out_elim     = 1'b1;
            out_clean_hi = 1'b1;
            pick_tag     = '0;
        end else if (copy_cand && !src_sat) begin
            out_elim = 1'b1;
            pick_tag = in_src_tag;
        end else begin
            out_port = 1'b1;
            out_lat  = slow_hi ? 2'd2 : 2'd1;
        end
        if (!in_valid) begin
            out_elim     = 1'b0;
            out_port     = 1'b0;
            out_clean_hi = 1'b0;
        end
    end

    assign out_tag      = pick_tag;
    assign out_free     = in_valid && (in_old_tag != '0) && (in_old_tag != pick_tag) && old_last;
    assign out_free_tag = in_old_tag;
endmodule

// Checker for the move-elimination unit.
module me_rename_elim_chk #(
    parameter int ARCH_W = 4,
    parameter int TAG_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_op,
    input logic [ARCH_W-1:0] in_dst,
    input logic [ARCH_W-1:0] in_src,
    input logic [TAG_W-1:0]  in_src_tag,
    input logic [TAG_W-1:0]  in_new_tag,
    input logic              out_elim,
    input logic              out_port,
    input logic [TAG_W-1:0]  out_tag,
    input logic [1:0]        out_lat,
    input logic              out_clean_hi,
    input logic              out_free,
    input logic [TAG_W-1:0]  out_free_tag
);
    a_r1_zero_idiom: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd1 && in_dst == in_src)
        |-> (out_elim && !out_port && out_tag == '0 && out_clean_hi && out_lat == 2'd0));
    a_r5_same_reg_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 3'd2 || in_op == 3'd3) && in_dst == in_src)
        |-> (!out_elim && out_port && out_tag == in_new_tag));
    a_r6_hi_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd4) |-> (!out_elim && out_lat == 2'd2));
    a_r3_elim_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (out_elim && in_op == 3'd2) |-> (out_tag == in_src_tag && !out_port));
    a_r8_zero_never_freed: assert property (@(posedge clk) disable iff (!rst_n)
        out_free |-> (out_free_tag != '0));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!out_elim && !out_port && !out_free && !out_clean_hi));
endmodule

bind me_rename_elim me_rename_elim_chk #(.ARCH_W(ARCH_W), .TAG_W(TAG_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src(in_src), .in_src_tag(in_src_tag),
    .in_new_tag(in_new_tag), .out_elim(out_elim), .out_port(out_port),
    .out_tag(out_tag), .out_lat(out_lat), .out_clean_hi(out_clean_hi),
    .out_free(out_free), .out_free_tag(out_free_tag)
);

// File: tb/test_me_rename_elim.sv
module test_me_rename_elim;
    localparam int NA = 8;
    localparam int NP = 16;
    localparam int CW = 2;
    localparam int AW = $clog2(NA);
    localparam int TW = $clog2(NP);
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [2:0] in_op = '0;
    logic [AW-1:0] in_dst = '0, in_src = '0;
    logic [TW-1:0] in_src_tag = '0, in_new_tag = '0, in_old_tag = '0;
    logic out_elim, out_port, out_clean_hi, out_free;
    logic [TW-1:0] out_tag, out_free_tag;
    logic [1:0] out_lat;

    int total = 0;
    int bad = 0;
    int map [NA];
    int cnt [NP];

    always #2.5 clk = ~clk;

    me_rename_elim #(.NUM_ARCH(NA), .NUM_PHYS(NP), .CNT_W(CW)) i_me_rename_elim (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src(in_src), .in_src_tag(in_src_tag),
        .in_new_tag(in_new_tag), .in_old_tag(in_old_tag),
        .out_elim(out_elim), .out_port(out_port), .out_tag(out_tag),
        .out_lat(out_lat), .out_clean_hi(out_clean_hi),
        .out_free(out_free), .out_free_tag(out_free_tag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pick_free();
        for (int t = 1; t < NP; t++) if (cnt[t] == 0) return t;
        return 0;
    endfunction

    // Drive one uop, check all outputs against the model, then commit.
    task automatic issue(input int op, input int d, input int s, input string req);
        int st, old, nt, tg, lat, fr;
        bit zero, mv, el;
        @(negedge clk);
        st = map[s]; old = map[d]; nt = pick_free();
        in_valid = 1'b1; in_op = 3'(op); in_dst = AW'(d); in_src = AW'(s);
        in_src_tag = TW'(st); in_new_tag = TW'(nt); in_old_tag = TW'(old);
        #1;
        zero = (op == 1) && (d == s);
        mv   = (op == 2 || op == 3) && (d != s);
        el   = zero || (mv && cnt[st] != CMAX);
        tg   = zero ? 0 : (el ? st : nt);
        lat  = el ? 0 : (op == 4 ? 2 : 1);
        fr   = (old != 0 && old != tg && cnt[old] == 1) ? 1 : 0;
        chk(req, "elim", int'(out_elim), int'(el));
        chk(req, "port", int'(out_port), int'(!el));
        chk(req, "tag", int'(out_tag), tg);
        chk(req, "lat", int'(out_lat), lat);
        chk(req, "clean_hi", int'(out_clean_hi), int'(zero));
        chk("R8", "free", int'(out_free), fr);
        if (fr == 1) chk("R8", "free_tag", int'(out_free_tag), old);
        @(posedge clk);
        if (tg != old) begin
            if (tg != 0 && cnt[tg] < CMAX) cnt[tg]++;
            if (old != 0 && cnt[old] > 0) cnt[old]--;
        end
        map[d] = tg;
        #1 in_valid = 1'b0;
    endtask

    task automatic t_reset_and_idle();
        // R10: idle cycle with stray inputs leaves flags low and counts intact
        @(negedge clk);
        in_valid = 1'b0; in_op = 3'd2; in_dst = 3'd1; in_src = 3'd2;
        in_src_tag = TW'(3); in_new_tag = TW'(12); in_old_tag = TW'(2);
        #1;
        chk("R10", "elim", int'(out_elim), 0);
        chk("R10", "port", int'(out_port), 0);
        chk("R10", "free", int'(out_free), 0);
        // R8: reset mapping — overwrite r0 (tag 1) must free tag 1
        issue(0, 0, 0, "R7");
        // tag 2 still held once after the idle cycle: overwrite r1 frees it
        issue(6, 1, 1, "R7");
    endtask

    task automatic t_zero_and_xor();
        issue(1, 2, 2, "R1");
        issue(1, 3, 4, "R2");
        issue(1, 2, 2, "R1");
    endtask

    task automatic t_moves();
        issue(2, 4, 5, "R3");
        issue(2, 6, 5, "R3");
        issue(0, 5, 5, "R7");
        issue(0, 4, 4, "R7");
        issue(0, 6, 6, "R8");
        issue(3, 1, 7, "R4");
        issue(2, 3, 3, "R5");
        issue(3, 7, 7, "R5");
        issue(4, 0, 7, "R6");
        issue(5, 2, 3, "R7");
        issue(6, 4, 4, "R7");
    endtask

    task automatic t_saturate();
        issue(0, 7, 7, "R8");
        issue(2, 0, 7, "R3");
        issue(2, 1, 7, "R3");
        issue(2, 2, 7, "R9");
        issue(3, 3, 7, "R9");
        issue(0, 0, 0, "R8");
        issue(2, 2, 7, "R3");
        issue(2, 5, 7, "R3");
    endtask

    initial begin : watchdog
        #500000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < NA; a++) map[a] = a + 1;
        for (int t = 0; t < NP; t++) cnt[t] = (t >= 1 && t <= NA) ? 1 : 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset_and_idle();
        t_zero_and_xor();
        t_moves();
        t_saturate();
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule